// File: doc/BRIEF.md
# I2C Memory Byte-Write Master

This block is the only master on a two-wire serial bus. Its job is to write one byte into a memory-style target that uses a 16-bit internal address. A request carries a 7-bit target address, a 16-bit memory address and one data byte. When the request is accepted, the block produces a START condition. It then shifts out four bytes, most significant bit first: the control byte, the high address byte, the low address byte and the data byte. After each byte it checks the acknowledge bit, and it closes the transfer with a STOP condition. If a byte is not acknowledged, the block abandons the rest of the transfer. It still issues STOP, and it raises an error flag that stays set.

Both bus lines are open drain. The block never drives a line high. Its outputs `scl_pull` and `sda_pull` mean "hold the line low", and both lines are read back through two-stage synchronizers. A target may hold SCL low to stall the transfer. The block does not start timing an SCL high phase until it reads SCL high.

The request side is a valid/ready handshake. `req_ready` is high only while the block is idle, and a request is taken on a clock edge where both `req_valid` and `req_ready` are high. There is no queue. A `req_valid` that is raised and then dropped while the block is busy is never taken. A requester that must not lose a command holds `req_valid` until it sees `req_ready`.

Top module: `i2c_mw_master`

## Requirements
- R1: During and after reset, with no request, both pull outputs are 0, `busy`, `done` and `nack_err` are 0, and `req_ready` is 1.
- R2: A request is accepted only on an edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the accepting edge until the transfer ends. A `req_valid` asserted and released while busy starts no transfer and does not change the bytes being sent.
- R3: START: on the accepting edge `sda_pull` goes to 1 while `scl_pull` stays 0. After HALF cycles `scl_pull` goes to 1. HALF = CLK_HZ / (2 * SCL_HZ).
- R4: The four bytes are sent in this order, each MSB first: {dev[6:0], 0}, then addr[15:8], then addr[7:0], then data. A 0 bit is sent as `sda_pull`=1 and a 1 bit as `sda_pull`=0.
- R5: Between START and STOP, SDA changes only while SCL is low. Each bit is set up HALF/2 cycles after SCL is pulled low.
- R6: On the ninth clock of each byte `sda_pull` is 0. The synchronized SDA is sampled at the end of the SCL high phase, and a low level means acknowledge.
- R7: A high level in the acknowledge slot ends the transfer with STOP and sets `nack_err`. `nack_err` stays 1 until the next request is accepted, which clears it.
- R8: STOP: with SDA pulled, `scl_pull` goes to 0. HALF+SYNC_STAGES cycles later `sda_pull` goes to 0. HALF cycles after that the transfer ends.
- R9: Without stretching, each SCL low phase lasts HALF cycles and each high phase lasts SYNC_STAGES+HALF cycles. The last edge of a transfer of B bytes comes HALF + 9·B·(2·HALF+SYNC_STAGES) + 3·HALF + SYNC_STAGES edges after the accepting edge.
- R10: While the synchronized SCL reads low in a high phase, the phase does not advance. A stretched transfer still delivers the correct bytes and acknowledges and only takes longer.
- R11: `done` is a one-cycle pulse on the edge where `busy` falls, after both a complete transfer and an aborted one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; request taken when both are high |
| req_dev | input | 7 | Target device address |
| req_mem_addr | input | 16 | Memory address inside the target |
| req_data | input | 8 | Byte to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| nack_err | output | 1 | Sticky missing-acknowledge flag |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |

## Verification
Every result is due at a cycle the bench computes in advance, counted in falling clock edges after the accepting edge (edge 1):
- **START:** visible at edge 1, with SCL pulled at edge HALF+1.
- **`done`:** exactly at edge N+1, where N is the R9 sum for the number of bytes sent, and low again one edge later.
- **STOP:** the SCL release must precede the SDA release by HALF+SYNC_STAGES edges, and the SDA release must come HALF edges before `done`.

A bus-level target model records the bytes, START/STOP events and acknowledge-slot levels. Run lengths of the SCL line are measured sample by sample and compared with HALF and SYNC_STAGES+HALF. Stretched runs are checked only for correct content and a longer duration, because their length depends on when the model releases the line.

// File: rtl/i2c_mw_pkg.sv
package i2c_mw_pkg;

  // Bus phases of one write transfer
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_LOW,
    PH_HIGH,
    PH_STOP_LOW,
    PH_STOP_HIGH,
    PH_STOP_REL
  } phase_e;

  localparam int unsigned SLOT_BITS  = 9;  // eight data bits plus acknowledge
  localparam int unsigned XFER_BYTES = 4;  // control, addr hi, addr lo, data

endpackage

// File: rtl/i2c_mw_sync.sv
module i2c_mw_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  // Chain resets to the idle-high level of the bus
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/i2c_mw_halfper.sv
module i2c_mw_halfper #(
  parameter int unsigned HALF = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic hold,
  output logic expire,
  output logic at_mid
);

  localparam int unsigned CW = $clog2(HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);
  localparam logic [CW-1:0] MID  = CW'(HALF / 2);

  logic [CW-1:0] cnt;

  assign expire = !hold && !restart && (cnt == LAST);
  assign at_mid = !hold && (cnt == MID);

  // Count held at zero while a stretched clock line reads low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || expire) cnt <= '0;
    else if (!hold)            cnt <= cnt + CW'(1);
  end

endmodule

// File: rtl/i2c_mw_bitsel.sv
module i2c_mw_bitsel (
  input  logic [6:0]  dev,
  input  logic [15:0] mem_addr,
  input  logic [7:0]  data,
  input  logic [1:0]  byte_idx,
  input  logic [2:0]  bit_idx,
  output logic        bit_val
);

  logic [7:0] slot [4];
  logic [2:0] pos;

  assign slot[0] = {dev, 1'b0};        // write direction in bit 0
  assign slot[1] = mem_addr[15:8];
  assign slot[2] = mem_addr[7:0];
  assign slot[3] = data;

  assign pos     = 3'd7 - bit_idx;     // MSB first
  assign bit_val = slot[byte_idx][pos];

endmodule

// File: rtl/i2c_mw_master.sv
module i2c_mw_master
  import i2c_mw_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned SCL_HZ      = 100_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [6:0]  req_dev,
  input  logic [15:0] req_mem_addr,
  input  logic [7:0]  req_data,
  output logic        busy,
  output logic        done,
  output logic        nack_err,
  output logic        scl_pull,
  output logic        sda_pull,
  input  logic        scl_in,
  input  logic        sda_in
);

  localparam int unsigned HALF      = CLK_HZ / (2 * SCL_HZ);
  localparam logic [3:0]  ACK_SLOT  = 4'(SLOT_BITS - 1);
  localparam logic [1:0]  LAST_BYTE = 2'(XFER_BYTES - 1);

  phase_e      ph;
  logic [1:0]  byte_idx;
  logic [3:0]  bit_idx;
  logic [6:0]  dev_q;
  logic [15:0] addr_q;
  logic [7:0]  data_q;
  logic        sda_q;
  logic        done_q;
  logic        err_q;

  logic scl_s, sda_s;
  logic expire, at_mid, hold, accept, bit_val;

  i2c_mw_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s)
  );

  i2c_mw_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s)
  );

  // High phases wait for the line to read high before timing
  assign hold = ((ph == PH_HIGH) || (ph == PH_STOP_HIGH)) && !scl_s;

  i2c_mw_halfper #(.HALF(HALF)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(ph == PH_IDLE),
    .hold(hold), .expire(expire), .at_mid(at_mid)
  );

  i2c_mw_bitsel u_bitsel (
    .dev(dev_q), .mem_addr(addr_q), .data(data_q),
    .byte_idx(byte_idx), .bit_idx(bit_idx[2:0]), .bit_val(bit_val)
  );

  assign req_ready = (ph == PH_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      byte_idx <= '0;
      bit_idx  <= '0;
      dev_q    <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      sda_q    <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (accept) begin
            dev_q    <= req_dev;
            addr_q   <= req_mem_addr;
            data_q   <= req_data;
            err_q    <= 1'b0;
            sda_q    <= 1'b1;          // START: SDA falls with SCL high
            byte_idx <= '0;
            bit_idx  <= '0;
            ph       <= PH_START;
          end
        end
        PH_START: begin
          if (expire) ph <= PH_LOW;
        end
        PH_LOW: begin
          if (at_mid) sda_q <= (bit_idx == ACK_SLOT) ? 1'b0 : !bit_val;
          if (expire) ph <= PH_HIGH;
        end
        PH_HIGH: begin
          if (expire) begin
            if (bit_idx == ACK_SLOT) begin
              if (sda_s || (byte_idx == LAST_BYTE)) begin
                if (sda_s) err_q <= 1'b1;
                ph <= PH_STOP_LOW;
              end else begin
                byte_idx <= byte_idx + 2'd1;
                bit_idx  <= '0;
                ph       <= PH_LOW;
              end
            end else begin
              bit_idx <= bit_idx + 4'd1;
              ph      <= PH_LOW;
            end
          end
        end
        PH_STOP_LOW: begin
          if (at_mid) sda_q <= 1'b1;
          if (expire) ph <= PH_STOP_HIGH;
        end
        PH_STOP_HIGH: begin
          if (expire) begin
            sda_q <= 1'b0;               // STOP: SDA rises with SCL high
            ph    <= PH_STOP_REL;
          end
        end
        PH_STOP_REL: begin
          if (expire) begin
            done_q <= 1'b1;
            ph     <= PH_IDLE;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign scl_pull = (ph == PH_LOW) || (ph == PH_STOP_LOW);
  assign sda_pull = sda_q;
  assign busy     = (ph != PH_IDLE);
  assign done     = done_q;
  assign nack_err = err_q;

endmodule

// File: rtl/i2c_mw_master_chk.sv
module i2c_mw_master_chk
  import i2c_mw_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   req_ready,
  input logic   busy,
  input logic   done,
  input logic   nack_err,
  input logic   scl_pull,
  input logic   sda_pull,
  input logic   scl_s,
  input logic   sda_s,
  input phase_e ph
);

  assert_start_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (sda_pull && !scl_pull));

  assert_start_scl_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_START) |-> !scl_pull);

  assert_sda_stable_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph == PH_HIGH) && $past(ph == PH_HIGH)) |-> $stable(sda_pull));

  assert_stretch_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph == PH_HIGH) && !scl_s) |=> (ph == PH_HIGH));

  assert_nack_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_err) |-> ($past(sda_s) && $past(ph == PH_HIGH)));

  assert_err_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !nack_err);

  assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!scl_pull && !sda_pull && $past(!sda_pull)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_at_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && req_ready && $past(busy)));

endmodule

bind i2c_mw_master i2c_mw_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .busy(busy), .done(done),
  .nack_err(nack_err), .scl_pull(scl_pull), .sda_pull(sda_pull),
  .scl_s(scl_s), .sda_s(sda_s), .ph(ph)
);

// File: tb/i2c_mw_master_tb.sv
module i2c_mw_master_tb;

  localparam int CLK_HZ = 4_000_000;
  localparam int SCL_HZ = 400_000;
  localparam int SYNC   = 2;
  localparam int H      = CLK_HZ / (2 * SCL_HZ);

  // 20-unit period: 50 MHz with 1 ns units
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [6:0]  req_dev = '0;
  logic [15:0] req_mem_addr = '0;
  logic [7:0]  req_data = '0;
  wire         req_ready, busy, done, nack_err, scl_pull, sda_pull;

  logic s_scl_hold = 1'b0;
  logic s_sda_pull = 1'b0;
  wire  scl_line = ~(scl_pull | s_scl_hold);
  wire  sda_line = ~(sda_pull | s_sda_pull);

  i2c_mw_master #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dev(req_dev), .req_mem_addr(req_mem_addr), .req_data(req_data),
    .busy(busy), .done(done), .nack_err(nack_err),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .scl_in(scl_line), .sda_in(sda_line)
  );

  int checks = 0;
  int errors = 0;

  task automatic check_eq(input string tag, input string what,
                          input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Target model on the bus
  int starts = 0, stops = 0, bitcnt = 0, byte_n = 0;
  int nack_at = -1, stretch_len = 0, ack_bad = 0;
  logic [7:0] sh = '0;
  logic [7:0] rx [4];

  always @(negedge sda_line) if (rst_n && scl_line === 1'b1) begin
    starts++; bitcnt = 0; byte_n = 0;
  end

  always @(posedge sda_line) if (rst_n && scl_line === 1'b1) stops++;

  always @(posedge scl_line) if (rst_n) begin
    if (bitcnt < 8) begin
      sh = {sh[6:0], sda_line};
      bitcnt++;
    end else begin
      if ((byte_n - 1) == nack_at && sda_line !== 1'b1) ack_bad++;
      bitcnt = 0;
    end
  end

  always @(negedge scl_line) if (rst_n) begin
    if (bitcnt == 8) begin
      if (byte_n < 4) rx[byte_n] = sh;
      s_sda_pull = (byte_n != nack_at);
      byte_n++;
      if (stretch_len > 0) begin
        s_scl_hold = 1'b1;
        repeat (stretch_len) @(negedge clk);
        s_scl_hold = 1'b0;
      end
    end else if (bitcnt == 0) begin
      s_sda_pull = 1'b0;
    end
  end

  task automatic run_txn(input logic [6:0] dev, input logic [15:0] ma,
                         input logic [7:0] dt, input int nk, input int st,
                         input bit poke);
    logic [7:0] exp_b [4];
    int nb, nexp, done_n, min_lo, min_hi, run, n_scl_rel, n_sda_rel;
    bit started;
    logic prev_line, prev_sclp, prev_sdap;
    exp_b[0] = {dev, 1'b0};
    exp_b[1] = ma[15:8];
    exp_b[2] = ma[7:0];
    exp_b[3] = dt;
    nb   = (nk < 0) ? 4 : nk + 1;
    nexp = H + 9 * nb * (2 * H + SYNC) + 3 * H + SYNC;
    starts = 0; stops = 0; bitcnt = 0; byte_n = 0; ack_bad = 0;
    nack_at = nk; stretch_len = st;
    for (int i = 0; i < 4; i++) rx[i] = 8'h00;
    done_n = -1; min_lo = 1_000_000; min_hi = 1_000_000; run = 0;
    n_scl_rel = -1; n_sda_rel = -1; started = 1'b0;

    @(negedge clk);
    check_eq("R2", "ready before request", req_ready, 1);
    req_valid = 1'b1; req_dev = dev; req_mem_addr = ma; req_data = dt;
    prev_line = scl_line; prev_sclp = scl_pull; prev_sdap = sda_pull;

    for (int n = 1; n <= 20000; n++) begin
      @(negedge clk);
      if (n == 1) begin
        req_valid = 1'b0;
        check_eq("R2", "busy after accept", busy, 1);
        check_eq("R2", "ready after accept", req_ready, 0);
        check_eq("R3", "sda pulled at start", sda_pull, 1);
        check_eq("R3", "scl free at start", scl_pull, 0);
        check_eq("R7", "error cleared on accept", nack_err, 0);
      end
      if (n == H) check_eq("R3", "scl free through start hold", scl_pull, 0);
      if (n == H + 1) check_eq("R3", "scl pulled after start hold", scl_pull, 1);
      if (poke && n >= 30 && n <= 34) begin
        if (n == 30) begin
          req_valid = 1'b1; req_dev = ~dev; req_mem_addr = ~ma; req_data = ~dt;
        end
        check_eq("R2", "ready while busy", req_ready, 0);
        if (n == 34) req_valid = 1'b0;
      end
      if (scl_line !== prev_line) begin
        if (started) begin
          if (prev_line) min_hi = (run < min_hi) ? run : min_hi;
          else           min_lo = (run < min_lo) ? run : min_lo;
        end
        started = 1'b1;
        run = 1;
      end else begin
        run++;
      end
      if (prev_sclp && !scl_pull) n_scl_rel = n;
      if (prev_sdap && !sda_pull) n_sda_rel = n;
      prev_line = scl_line; prev_sclp = scl_pull; prev_sdap = sda_pull;
      if (done) begin
        done_n = n;
        break;
      end
    end

    check_eq("R11", "done seen", (done_n > 0) ? 1 : 0, 1);
    if (st == 0) begin
      check_eq("R9", "done edge", done_n, nexp + 1);
      check_eq("R9", "min scl high run", min_hi, H + SYNC);
    end else begin
      check_eq("R10", "stretched transfer longer", (done_n > nexp + 1) ? 1 : 0, 1);
      check_eq("R10", "high run at least half", (min_hi >= H) ? 1 : 0, 1);
    end
    check_eq("R9", "min scl low run", min_lo, H);
    check_eq("R8", "stop scl-to-sda gap", n_sda_rel - n_scl_rel, H + SYNC);
    check_eq("R8", "stop sda release before done", done_n - n_sda_rel, H);
    check_eq("R5", "start count", starts, 1);
    check_eq("R8", "stop count", stops, 1);
    check_eq("R6", "bytes clocked", byte_n, nb);
    for (int i = 0; i < 4; i++)
      if (i < nb) check_eq("R4", $sformatf("byte %0d", i), rx[i], exp_b[i]);
    check_eq("R6", "sda released in nacked slot", ack_bad, 0);
    check_eq("R7", "error flag", nack_err, (nk >= 0) ? 1 : 0);

    @(negedge clk);
    check_eq("R11", "done one cycle", done, 0);
    check_eq("R11", "busy after done", busy, 0);
    check_eq("R2", "ready after done", req_ready, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      check_eq("R2", "no queued transfer", busy, 0);
      check_eq("R2", "no extra start", starts, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check_eq("R1", "scl_pull in reset", scl_pull, 0);
    check_eq("R1", "sda_pull in reset", sda_pull, 0);
    check_eq("R1", "busy in reset", busy, 0);
    check_eq("R1", "done in reset", done, 0);
    check_eq("R1", "err in reset", nack_err, 0);
    check_eq("R1", "ready in reset", req_ready, 1);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check_eq("R1", "idle lines", {scl_pull, sda_pull, busy, done}, 0);

    // Main sweep of address and data patterns
    run_txn(7'h00, 16'h0000, 8'h00, -1, 0, 0);
    run_txn(7'h7F, 16'hFFFF, 8'hFF, -1, 0, 0);
    run_txn(7'h55, 16'hAA55, 8'hA5, -1, 0, 0);
    for (int i = 0; i < 6; i++)
      run_txn(7'(i * 19 + 3), 16'(i * 4099 + 16'h1234), 8'(i * 37 + 1), -1, 0, 0);

    // Missing acknowledge at each byte position
    for (int p = 0; p < 4; p++) begin
      run_txn(7'(p * 11 + 40), 16'(p * 777 + 16'h0F0F), 8'(p * 29 + 3), p, 0, 0);
      repeat (10) @(negedge clk);
      check_eq("R7", "error sticky while idle", nack_err, 1);
    end
    run_txn(7'h21, 16'h3C3C, 8'h5A, -1, 0, 0);

    // Clock stretching
    run_txn(7'h50, 16'hBEEF, 8'h3C, -1, 12, 0);
    run_txn(7'h0A, 16'h0102, 8'hC3, -1, 40, 0);
    run_txn(7'h33, 16'h4444, 8'h99, 2, 25, 0);

    // Request raised while busy
    run_txn(7'h1B, 16'h7E81, 8'h66, -1, 0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule